// File: doc/BRIEF.md
# Context Save Stack with Masked Restore

This block is the return-address and context store of a small nibble-wide processor. On every subroutine call or interrupt entry, the core presents its whole working context on one 53-bit bus and pulses a push. That context is the program counter plus every page, bank and pointer register, together with the accumulator and the carry. The stack keeps sixteen of these snapshots.

On a return, the core pulses a pop together with a 7-bit group mask. The block presents the most recent snapshot one cycle later. It also raises a program-counter strobe, which fires on every pop, and a group strobe for each mask bit that is set. The register file reloads exactly the groups that are strobed, so a plain return with a zero mask touches only the program counter.

The stack is a ring. A seventeenth push silently replaces the oldest snapshot. A pop on an empty stack simply yields whatever sits at the wrapped index, and no error is raised in either case.

Top module: `ctx_stack`

## Requirements
- R1: While reset is held, and directly after it is released, `ctx_o` is all zeros and `restore_pc_o` and `restore_grp_o` are low.
- R2: A push stores all 53 bits of `ctx_i`. Pops return the stored snapshots in last-in, first-out order. The data appears on `ctx_o` in the cycle after the clock edge that sampled the pop.
- R3: Each pop gives a one-cycle pulse on `restore_pc_o` in the same cycle as its data. Without a new pop, the pulse is low again one cycle later.
- R4: `restore_grp_o` equals the pop's mask during the data cycle. The mask bits select groups as follows: bit0 table pointers `ctx_o[37:22]`; bit1 data bank `ctx_o[21:16]` (low nibble `[21:18]`, high pair `[17:16]`); bit2 working-register page `[15:12]`; bit3 ROM page `[11:8]`; bit4 RAM page `[7:5]`; bit5 accumulator `[4:1]`; bit6 carry `[0]`. The program counter is `ctx_o[52:38]`.
- R5: A pop with a zero mask raises `restore_pc_o` only, with `restore_grp_o` all zero.
- R6: After more than 16 pushes, the oldest snapshots are overwritten. The next 16 pops return the 16 most recent snapshots, newest first.
- R7: The stack pointer wraps in both directions. A pop right after reset returns the entry at index 15, which is all zeros, and raises the strobes normally. A 17th pop after 16 pops of a full ring returns the newest snapshot again.
- R8: When push and pop are asserted together, only the push takes place. No strobe rises in the next cycle, and the pushed snapshot is the one the next pop returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Save `ctx_i` as a new snapshot |
| pop_i | input | 1 | Restore the newest snapshot |
| ctx_i | input | 53 | Context to save, laid out as in R4 |
| mask_i | input | 7 | Groups to restore besides the program counter |
| ctx_o | output | 53 | Popped snapshot, laid out as in R4 |
| restore_pc_o | output | 1 | Program counter reload strobe |
| restore_grp_o | output | 7 | Per-group reload strobes |

## Verification
Two situations are hard to reach from the ports: the ring state after an overflow, and a pop issued when nothing has been pushed. Both are invisible until the wrong snapshot comes out. The bench pushes 17 distinct, computed snapshots and unwinds all 16 survivors. It then pops once more to show that the pointer has come back around. Separately, it pops straight out of reset to read the wrapped index 15, and it drives push and pop in the same cycle before popping the survivor.

// File: rtl/ctx_stack_pkg.sv
package ctx_stack_pkg;
  parameter int PC_W   = 15;
  parameter int NIB_W  = 4;
  parameter int TAB_N  = 4;
  parameter int BKH_W  = 2;
  parameter int RAMP_W = 3;
  parameter int GRP_N  = 7;
  localparam int CTX_W = PC_W + TAB_N*NIB_W + NIB_W + BKH_W + 3*NIB_W + RAMP_W + 1;

  typedef struct packed {
    logic [PC_W-1:0]             pc;
    logic [TAB_N-1:0][NIB_W-1:0] tab;
    logic [NIB_W-1:0]            bank_lo;
    logic [BKH_W-1:0]            bank_hi;
    logic [NIB_W-1:0]            wr_page;
    logic [NIB_W-1:0]            rom_page;
    logic [RAMP_W-1:0]           ram_page;
    logic [NIB_W-1:0]            acc;
    logic                        cy;
  } ctx_t;

  function automatic logic [GRP_N-1:0] grp_fire(input logic fire, input logic [GRP_N-1:0] m);
    return fire ? m : '0;
  endfunction

  function automatic int unsigned idx_step(input int unsigned idx, input logic up, input int unsigned depth);
    return up ? (idx + 1) % depth : (idx + depth - 1) % depth;
  endfunction
endpackage

// File: rtl/ctx_stack_ptr.sv
module ctx_stack_ptr #(
  parameter int DEPTH = 16,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_en,
  input  logic          pop_en,
  output logic [PW-1:0] wr_idx,
  output logic [PW-1:0] rd_idx
);
  import ctx_stack_pkg::*;
  logic [PW-1:0] sp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sp_q <= '0;
    else if (push_en) sp_q <= PW'(idx_step(int'(sp_q), 1'b1, DEPTH));
    else if (pop_en)  sp_q <= PW'(idx_step(int'(sp_q), 1'b0, DEPTH));
  end

  assign wr_idx = sp_q;
  assign rd_idx = PW'(idx_step(int'(sp_q), 1'b0, DEPTH));

  p_ring_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |=> PW'(sp_q - $past(sp_q)) == PW'(1));
  p_ring_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_en && !push_en) |=> PW'($past(sp_q) - sp_q) == PW'(1));
endmodule

// File: rtl/ctx_stack_mem.sv
module ctx_stack_mem #(
  parameter int DEPTH = 16,
  localparam int PW = $clog2(DEPTH),
  localparam int W  = ctx_stack_pkg::CTX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  input  logic [PW-1:0] rd_idx,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] slot_q [DEPTH];
  logic [W-1:0] rd_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             slot_q[g] <= '0;
      else if (wr_en && wr_idx == PW'(g))     slot_q[g] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= slot_q[rd_idx];
  end
  assign rd_data = rd_q;

  p_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> slot_q[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/ctx_restore_gate.sv
module ctx_restore_gate #(
  parameter int GN = ctx_stack_pkg::GRP_N
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop_en,
  input  logic [GN-1:0] mask,
  output logic          pc_stb,
  output logic [GN-1:0] grp_stb
);
  import ctx_stack_pkg::*;
  logic          pc_q;
  logic [GN-1:0] grp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= 1'b0;
      grp_q <= '0;
    end else begin
      pc_q  <= pop_en;
      grp_q <= grp_fire(pop_en, mask);
    end
  end
  assign pc_stb  = pc_q;
  assign grp_stb = grp_q;

  p_grp_needs_pc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|grp_stb) |-> pc_stb);
  p_pulse_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !pop_en |=> !pc_stb);
endmodule

// File: rtl/ctx_stack.sv
module ctx_stack #(
  parameter int DEPTH = 16,
  localparam int PW = $clog2(DEPTH),
  localparam int W  = ctx_stack_pkg::CTX_W,
  localparam int GN = ctx_stack_pkg::GRP_N
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [W-1:0]  ctx_i,
  input  logic [GN-1:0] mask_i,
  output logic [W-1:0]  ctx_o,
  output logic          restore_pc_o,
  output logic [GN-1:0] restore_grp_o
);
  logic          push_eff;
  logic          pop_eff;
  logic [PW-1:0] wr_idx;
  logic [PW-1:0] rd_idx;

  // push wins a simultaneous request
  assign push_eff = push_i;
  assign pop_eff  = pop_i && !push_i;

  ctx_stack_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst_n(rst_n), .push_en(push_eff), .pop_en(pop_eff),
    .wr_idx(wr_idx), .rd_idx(rd_idx)
  );

  ctx_stack_mem #(.DEPTH(DEPTH)) u_mem (
    .clk(clk), .rst_n(rst_n), .wr_en(push_eff), .wr_idx(wr_idx), .wr_data(ctx_i),
    .rd_en(pop_eff), .rd_idx(rd_idx), .rd_data(ctx_o)
  );

  ctx_restore_gate #(.GN(GN)) u_gate (
    .clk(clk), .rst_n(rst_n), .pop_en(pop_eff), .mask(mask_i),
    .pc_stb(restore_pc_o), .grp_stb(restore_grp_o)
  );

  p_both_no_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i) |=> !restore_pc_o);
  p_pop_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i) |=> restore_pc_o);
  p_grp_within_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    restore_pc_o |-> (restore_grp_o & ~$past(mask_i)) == '0);
endmodule

// File: tb/sim_ctx_stack.sv
module sim_ctx_stack;
  localparam int PERIOD = 10;
  localparam int W = 53;

  localparam logic [W-1:0] VEC [8] = '{
    53'h0A5_1234_5678_9A, 53'h1F_FFFF_FFFF_FFFF, 53'h000_0000_0000_01, 53'h10_0000_0000_0000,
    53'h0C3_C3C3_C3C3_C3, 53'h05A_5A5A_5A5A_5A, 53'h0FE_DCBA_9876_54, 53'h001_0203_0405_06};
  localparam logic [6:0] MSK [8] = '{7'h00, 7'h01, 7'h02, 7'h04, 7'h08, 7'h10, 7'h20, 7'h40};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push_i = 1'b0, pop_i = 1'b0;
  logic [W-1:0] ctx_i = '0;
  logic [6:0] mask_i = '0;
  logic [W-1:0] ctx_o;
  logic restore_pc_o;
  logic [6:0] restore_grp_o;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  ctx_stack u0 (.clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i), .ctx_i(ctx_i),
    .mask_i(mask_i), .ctx_o(ctx_o), .restore_pc_o(restore_pc_o), .restore_grp_o(restore_grp_o));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; push_i = 0; pop_i = 0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic do_push(input logic [W-1:0] d);
    @(negedge clk); push_i = 1; pop_i = 0; ctx_i = d;
    @(negedge clk); push_i = 0;
  endtask

  task automatic do_pop(input logic [6:0] m, input string req, input logic [W-1:0] exp);
    @(negedge clk); pop_i = 1; push_i = 0; mask_i = m;
    @(negedge clk); pop_i = 0;
    chk({req, " data"}, 64'(ctx_o), 64'(exp));
    chk({req, " pc strobe"}, 64'(restore_pc_o), 64'd1);
    chk({req, " group strobes"}, 64'(restore_grp_o), 64'(m));
  endtask

  function automatic logic [W-1:0] pat(input int i);
    return {15'(i * 1021 + 3), 16'(i * 4099), 6'(i), 4'(~i), 4'(i + 5), 3'(i), 4'(i * 3), 1'(i)};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1 reset state
    #(PERIOD * 2 + 1);
    chk("R1 data in reset", 64'(ctx_o), 64'd0);
    chk("R1 strobes in reset", 64'({restore_pc_o, restore_grp_o}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 strobes after reset", 64'({restore_pc_o, restore_grp_o}), 64'd0);

    // R2 R4 table: push eight, pop eight with rotating masks
    for (int i = 0; i < 8; i++) do_push(VEC[i]);
    for (int i = 0; i < 8; i++) do_pop(MSK[i], "R2 R4 table pop", VEC[7 - i]);

    // R3 strobe drops one cycle later
    @(negedge clk);
    chk("R3 pulse ended", 64'({restore_pc_o, restore_grp_o}), 64'd0);

    // R5 zero mask, R4 all groups
    do_push(VEC[4]); do_push(VEC[5]);
    do_pop(7'h00, "R5 pc only", VEC[5]);
    do_pop(7'h7F, "R4 all groups", VEC[4]);

    // R7 empty pop right after reset
    do_reset();
    do_pop(7'h7F, "R7 empty pop", '0);

    // R8 simultaneous push and pop
    do_reset();
    do_push(VEC[1]);
    @(negedge clk); push_i = 1; pop_i = 1; ctx_i = VEC[6]; mask_i = 7'h7F;
    @(negedge clk); push_i = 0; pop_i = 0;
    chk("R8 no strobe", 64'({restore_pc_o, restore_grp_o}), 64'd0);
    do_pop(7'h03, "R8 pushed survivor", VEC[6]);
    do_pop(7'h00, "R8 older entry", VEC[1]);

    // R6 overflow: 17 pushes, 16 pops newest first, R7 17th pop wraps
    do_reset();
    for (int i = 0; i <= 16; i++) do_push(pat(i));
    for (int k = 0; k < 16; k++) do_pop(7'h11, "R6 overflow unwind", pat(16 - k));
    do_pop(7'h00, "R7 wrap after full unwind", pat(16));

    finish_run();
  end
endmodule